// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a 32-bit trigger word, written by one of several requesting CPUs, into pending software interrupts. The word names one of the software interrupt IDs and a rule for choosing targets. The rule can pick CPUs from an explicit bitmap, pick every CPU except the writer, or pick only the writer. For each chosen CPU, the block sets the pending flag of that ID. It also records which CPU raised the interrupt and the security attribute bit of the request.

Each target CPU sees a pending vector with one bit per ID. It also sees the recorded source CPU and the security bit of each entry, so the acknowledge logic can report them. A CPU retires an entry with its own clear strobe and ID. The block also exports the fixed trigger configuration code of the software interrupts.

Top module: `sgi_dispatch`

## Requirements
- R1: After a synchronous active-low reset, every pending flag, recorded source and security bit is zero.
- R2: Bits 3:0 of the trigger word select the interrupt ID. When the write strobe is sampled, the selected pending bits are visible on the next cycle.
- R3: Filter bits 25:24 = 00 targets exactly the CPUs whose bits are set in bitmap bits 23:16, where bit 16+k means CPU k. An all-zero bitmap raises nothing.
- R4: Filter 01 targets every CPU except the requester.
- R5: Filter 10 targets only the requester.
- R6: Filter 11 is reserved. Such a write changes no pending flag, source or security bit.
- R7: Each pending entry records the 3-bit requester CPU number. A new write to an already-pending entry overwrites the recorded source.
- R8: Bit 15 of the trigger word is stored with each entry it sets. A value of 0 means a secure request.
- R9: A clear strobe from CPU c with an ID clears that entry's pending flag on the next cycle. Other entries are left unchanged.
- R10: If a set and a clear hit the same entry in the same cycle, the set wins and the entry stays pending.
- R11: The trigger configuration output always reads 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_we | input | 1 | Trigger word write strobe |
| trig_wdata | input | 32 | Trigger word |
| trig_src | input | 3 | CPU number of the writer |
| ack_clr | input | 8 | Per-CPU clear strobe |
| ack_id | input | 32 | Per-CPU ID to clear, 4 bits per CPU (CPU k in bits 4k+3:4k) |
| pend | output | 128 | Pending vectors, 16 bits per CPU (CPU k in bits 16k+15:16k) |
| pend_src | output | 384 | Recorded source, 3 bits per entry (entry k*16+id) |
| pend_sec | output | 128 | Stored security bit per entry (same indexing as pend) |
| trig_cfg | output | 2 | Fixed trigger configuration code |

## Verification
The bench checks the filter corner cases, because a decoder that confuses 01 with 10 raises the wrong CPUs. It writes an all-zero bitmap with filter 00 and the reserved filter 11; a design that defaults either case to broadcast would set stray pending bits. It rewrites an entry that is already pending from a different requester; a design that keeps the first source would report a stale CPU on acknowledge. It issues a clear and a set to the same entry in the same cycle; a design with the wrong priority would drop the new interrupt.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int NCPU  = 8;
    localparam int NID   = 16;
    localparam int CPUW  = $clog2(NCPU);
    localparam int IDW   = $clog2(NID);

    typedef enum logic [1:0] {
        FLT_LIST   = 2'b00,
        FLT_OTHERS = 2'b01,
        FLT_SELF   = 2'b10,
        FLT_RSVD   = 2'b11
    } filter_e;

    localparam logic [1:0] SGI_CFG_CODE = 2'b10;
endpackage

// File: rtl/sgi_decode.sv
// Trigger decoder: turns a trigger word and requester number into a set of
// target CPUs, an ID and a security bit. It assumes the word is valid only
// while the write strobe is high. The reserved filter code yields no targets.
module sgi_decode
    import sgi_pkg::*;
#(
    parameter int NC = NCPU,
    parameter int NI = NID
) (
    input  logic                    we,
    input  logic [31:0]             wdata,
    input  logic [$clog2(NC)-1:0]   src,
    output logic [NC-1:0]           tgt,
    output logic [$clog2(NI)-1:0]   id,
    output logic                    sec
);
    filter_e         flt;
    logic [NC-1:0]   self_oh;

    assign flt = filter_e'(wdata[25:24]);
    assign id  = wdata[$clog2(NI)-1:0];
    assign sec = wdata[15];

    // Build a one-hot mask of the requester
    always_comb begin
        self_oh      = '0;
        self_oh[src] = 1'b1;
    end

    // Choose the target set from the filter code
    always_comb begin
        tgt = '0;
        if (we) begin
            case (flt)
                FLT_LIST:   tgt = wdata[16 +: NC];
                FLT_OTHERS: tgt = ~self_oh;
                FLT_SELF:   tgt = self_oh;
                default:    tgt = '0;
            endcase
        end
    end
endmodule

// File: rtl/sgi_cpu_bank.sv
// Storage for one target CPU: a pending flag, source and security bit per ID.
// It assumes at most one set ID and one clear ID per cycle. When both name
// the same ID in the same cycle, the set wins.
module sgi_cpu_bank #(
    parameter int NI = 16,
    parameter int CW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [$clog2(NI)-1:0] set_id,
    input  logic [CW-1:0]         set_src,
    input  logic                  set_sec,
    input  logic                  clr_en,
    input  logic [$clog2(NI)-1:0] clr_id,
    output logic [NI-1:0]         pend,
    output logic [NI*CW-1:0]      src,
    output logic [NI-1:0]         sec
);
    for (genvar i = 0; i < NI; i++) begin : g_id
        logic hit_set, hit_clr;
        assign hit_set = set_en && (set_id == i[$clog2(NI)-1:0]);
        assign hit_clr = clr_en && (clr_id == i[$clog2(NI)-1:0]);

        // Update one entry: reset, then set before clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i]           <= 1'b0;
                src[i*CW +: CW]   <= '0;
                sec[i]            <= 1'b0;
            end else if (hit_set) begin
                pend[i]           <= 1'b1;
                src[i*CW +: CW]   <= set_src;
                sec[i]            <= set_sec;
            end else if (hit_clr) begin
                pend[i]           <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
// Top of the software-interrupt dispatcher. It decodes trigger writes and
// fans them out to one storage bank per target CPU. It assumes one trigger
// write per cycle and a synchronous active-low reset.
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NC = NCPU,
    parameter int NI = NID
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trig_we,
    input  logic [31:0]                  trig_wdata,
    input  logic [$clog2(NC)-1:0]        trig_src,
    input  logic [NC-1:0]                ack_clr,
    input  logic [NC*$clog2(NI)-1:0]     ack_id,
    output logic [NC*NI-1:0]             pend,
    output logic [NC*NI*$clog2(NC)-1:0]  pend_src,
    output logic [NC*NI-1:0]             pend_sec,
    output logic [1:0]                   trig_cfg
);
    localparam int CW = $clog2(NC);
    localparam int IW = $clog2(NI);

    logic [NC-1:0] tgt;
    logic [IW-1:0] dec_id;
    logic          dec_sec;

    assign trig_cfg = SGI_CFG_CODE;

    sgi_decode #(.NC(NC), .NI(NI)) u_dec (
        .we    (trig_we),
        .wdata (trig_wdata),
        .src   (trig_src),
        .tgt   (tgt),
        .id    (dec_id),
        .sec   (dec_sec)
    );

    for (genvar c = 0; c < NC; c++) begin : g_cpu
        sgi_cpu_bank #(.NI(NI), .CW(CW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (tgt[c]),
            .set_id  (dec_id),
            .set_src (trig_src),
            .set_sec (dec_sec),
            .clr_en  (ack_clr[c]),
            .clr_id  (ack_id[c*IW +: IW]),
            .pend    (pend[c*NI +: NI]),
            .src     (pend_src[c*NI*CW +: NI*CW]),
            .sec     (pend_sec[c*NI +: NI])
        );
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
// Checker for the dispatcher. It watches only the ports of the top module.
module sgi_dispatch_chk #(
    parameter int NC = 8,
    parameter int NI = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         trig_we,
    input logic [31:0]                  trig_wdata,
    input logic [$clog2(NC)-1:0]        trig_src,
    input logic [NC-1:0]                ack_clr,
    input logic [NC*NI-1:0]             pend,
    input logic [1:0]                   trig_cfg
);
    logic past_valid;

    // Mark the cycles after the first reset, so that $past sees real values
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> pend == '0);

    // R6
    rsvd_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && trig_we && trig_wdata[25:24] == 2'b11 && ack_clr == '0)
            |=> $stable(pend));

    // R3
    empty_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && trig_we && trig_wdata[25:16] == 10'd0 && ack_clr == '0)
            |=> $stable(pend));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !trig_we && ack_clr == '0) |=> $stable(pend));

    // R11
    cfg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_cfg == 2'b10);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NC(NC), .NI(NI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_we    (trig_we),
    .trig_wdata (trig_wdata),
    .trig_src   (trig_src),
    .ack_clr    (ack_clr),
    .pend       (pend),
    .trig_cfg   (trig_cfg)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
    localparam int NC = 8;
    localparam int NI = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_we = 1'b0;
    logic [31:0] trig_wdata = '0;
    logic [2:0]  trig_src = '0;
    logic [7:0]  ack_clr = '0;
    logic [31:0] ack_id = '0;
    logic [127:0] pend;
    logic [383:0] pend_src;
    logic [127:0] pend_sec;
    logic [1:0]  trig_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sgi_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_wdata(trig_wdata),
        .trig_src(trig_src), .ack_clr(ack_clr), .ack_id(ack_id),
        .pend(pend), .pend_src(pend_src), .pend_sec(pend_sec),
        .trig_cfg(trig_cfg)
    );

    function automatic logic [31:0] word(input logic [1:0] f, input logic [7:0] map,
                                         input logic sec, input logic [3:0] id);
        return {6'd0, f, map, sec, 11'd0, id};
    endfunction

    task automatic chk(input string req, input logic [383:0] act, input logic [383:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write on the falling edge; results are visible after the next rising edge
    task automatic wr(input logic [2:0] s, input logic [31:0] w);
        @(negedge clk);
        trig_we = 1'b1; trig_wdata = w; trig_src = s;
        @(negedge clk);
        trig_we = 1'b0; trig_wdata = '0;
    endtask

    task automatic clr(input int cpu, input logic [3:0] id);
        @(negedge clk);
        ack_clr[cpu] = 1'b1; ack_id[cpu*4 +: 4] = id;
        @(negedge clk);
        ack_clr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    function automatic logic [127:0] mask(input logic [7:0] cpus, input int id);
        logic [127:0] m = '0;
        for (int c = 0; c < 8; c++) if (cpus[c]) m[c*16+id] = 1'b1;
        return m;
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R1 pend", pend, '0);
        chk("R1 src", pend_src, '0);
        chk("R1 sec", pend_sec, '0);
        chk("R11 cfg", trig_cfg, 2'b10);
    endtask

    task automatic t_list();
        do_reset();
        wr(3'd0, word(2'b00, 8'b1010_0101, 1'b1, 4'd7));
        chk("R3 R2 list", pend, mask(8'b1010_0101, 7));
        chk("R8 sec", pend_sec, mask(8'b1010_0101, 7));
        wr(3'd1, word(2'b00, 8'h00, 1'b1, 4'd3));
        chk("R3 empty", pend, mask(8'b1010_0101, 7));
    endtask

    task automatic t_others();
        do_reset();
        wr(3'd5, word(2'b01, 8'h00, 1'b0, 4'd15));
        chk("R4 others", pend, mask(8'b1101_1111, 15));
        chk("R8 secure zero", pend_sec, '0);
        chk("R7 src", pend_src[(2*16+15)*3 +: 3], 3'd5);
    endtask

    task automatic t_self();
        do_reset();
        wr(3'd3, word(2'b10, 8'hFF, 1'b0, 4'd0));
        chk("R5 self", pend, mask(8'b0000_1000, 0));
    endtask

    task automatic t_rsvd();
        do_reset();
        wr(3'd2, word(2'b00, 8'h01, 1'b0, 4'd4));
        wr(3'd6, word(2'b11, 8'hFF, 1'b1, 4'd4));
        chk("R6 pend", pend, mask(8'h01, 4));
        chk("R6 src", pend_src[4*3 +: 3], 3'd2);
        chk("R6 sec", pend_sec, '0);
    endtask

    task automatic t_overwrite();
        do_reset();
        wr(3'd1, word(2'b00, 8'h80, 1'b0, 4'd9));
        chk("R7 first", pend_src[(7*16+9)*3 +: 3], 3'd1);
        wr(3'd6, word(2'b00, 8'h80, 1'b1, 4'd9));
        chk("R7 overwrite", pend_src[(7*16+9)*3 +: 3], 3'd6);
        chk("R8 overwrite", pend_sec[7*16+9], 1'b1);
    endtask

    task automatic t_clear();
        do_reset();
        wr(3'd0, word(2'b00, 8'h06, 1'b0, 4'd2));
        wr(3'd0, word(2'b00, 8'h02, 1'b0, 4'd11));
        clr(1, 4'd2);
        chk("R9 clear", pend, mask(8'h04, 2) | mask(8'h02, 11));
    endtask

    task automatic t_collide();
        do_reset();
        wr(3'd4, word(2'b00, 8'h01, 1'b0, 4'd6));
        @(negedge clk);
        trig_we = 1'b1; trig_wdata = word(2'b00, 8'h01, 1'b0, 4'd6); trig_src = 3'd7;
        ack_clr[0] = 1'b1; ack_id[3:0] = 4'd6;
        @(negedge clk);
        trig_we = 1'b0; ack_clr = '0;
        chk("R10 set wins", pend, mask(8'h01, 6));
        chk("R10 src", pend_src[6*3 +: 3], 3'd7);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_list();
        t_others();
        t_self();
        t_rsvd();
        t_overwrite();
        t_clear();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule